// File: doc/BRIEF.md
# Scan Channel Sequencer Controller

This block steers a single shared converter across three colour inputs of an image digitizer. It runs on the converter clock. A line-start strobe marks the active part of a scan line, and three configuration bits shape the order of sampling: a channel-count bit (three channels cycling, or one locked channel), a two-bit fixed-channel field, and a direction bit that picks the cycling order. Each cycle the block presents the channel to sample on `chan_sel` and raises `conv_start` while the strobe is high.

The converter returns its 12-bit result a fixed number of cycles (`LATENCY`) after the conversion was started, on `sample_in`. The block carries a tag for each conversion through a matching delay line. It then registers the returned word together with its channel and a first-of-line mark. The result stream is a one-cycle `out_valid` pulse per word with no ready input. The converter cannot be paused, so there is no back-pressure: a consumer that misses a pulse loses that word. The data pins drive only while the active-low output enable is asserted; otherwise they float.

Channel codes used throughout: 00 red, 01 green, 10 blue, 11 reserved.

Top module: `scan_seq_ctrl`

## Requirements
- R1: `conv_start` is high in exactly the cycles where `line_start` is high and `rst` is low. Each such cycle yields exactly one `out_valid` pulse, LATENCY+1 cycles later.
- R2: Once `line_start` has been low for one clock edge, the three-channel select rests on the first channel of the order: red (00) when `cfg_bgr` is 0, blue (10) when it is 1. A new line therefore starts on that channel.
- R3: In three-channel mode (`cfg_one_chan` = 0), while `line_start` stays high the select advances by one channel per clock and repeats every three clocks.
- R4: With `cfg_bgr` = 0 the order is red, green, blue (00, 01, 10). With `cfg_bgr` = 1 it is blue, green, red (10, 01, 00).
- R5: In one-channel mode (`cfg_one_chan` = 1) the select does not cycle. It equals `cfg_chan_sel` for codes 00, 01 and 10.
- R6: In one-channel mode the reserved code 11 selects red (00).
- R7: When `cfg_one_chan` is 0, the value of `cfg_chan_sel` has no effect on `chan_sel`.
- R8: Each output word equals `sample_in` as seen LATENCY cycles after its conversion started. `out_chan` is the channel selected at that start. `out_first` is high only for the first conversion after `line_start` rises.
- R9: `out_data` carries the last registered word while `out_en_n` is 0 and is high impedance while it is 1.
- R10: A synchronous reset clears `out_valid` and `out_first`, puts the select at the first channel of the order, and waits for a new rising `line_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| line_start | input | 1 | High while a scan line is being converted |
| cfg_one_chan | input | 1 | 0: three channels cycle, 1: one locked channel |
| cfg_chan_sel | input | 2 | Locked channel code in one-channel mode |
| cfg_bgr | input | 1 | Cycling order, 0: R-G-B, 1: B-G-R |
| sample_in | input | 12 | Converter result, LATENCY cycles after its start |
| out_en_n | input | 1 | Active-low drive enable for `out_data` |
| conv_start | output | 1 | Start a conversion on this clock edge |
| chan_sel | output | 2 | Channel routed to the converter this cycle |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_chan | output | 2 | Channel of the current result |
| out_first | output | 1 | Result is the first of its line |
| out_data | output | 12 | Result word, straight binary, tri-state |

## Verification
The assertions take the inputs to be synchronous to `clk`. They make no assumption that the configuration is held through a line: the cycling check ignores any cycle where the direction bit or the channel-count bit changed. The stimulus changes the configuration only while `line_start` is low, and it always drives `line_start` for whole clocks. It sweeps every combination of channel count, fixed-channel code and direction. Lines end at a position that is not a multiple of three, so the return to the first channel is exercised. The output enable is toggled on a pattern independent of the line, and one reset is applied while conversions are still in flight.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    CH_RED   = 2'b00,
    CH_GREEN = 2'b01,
    CH_BLUE  = 2'b10,
    CH_RSVD  = 2'b11
  } chan_e;

  typedef struct packed {
    logic  conv;
    logic  first;
    chan_e chan;
  } tag_t;

  // Position 0 is always the first channel of the programmed order.
  function automatic chan_e order_map(input logic [1:0] pos, input logic bgr);
    chan_e ch;
    case (pos)
      2'd0:    ch = bgr ? CH_BLUE : CH_RED;
      2'd1:    ch = CH_GREEN;
      default: ch = bgr ? CH_RED : CH_BLUE;
    endcase
    return ch;
  endfunction

endpackage

// File: rtl/scan_seq_order.sv
module scan_seq_order
  import scan_seq_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_start,
  input  logic       one_chan,
  input  logic       bgr,
  input  logic [1:0] fixed_sel,
  output chan_e      chan_sel,
  output logic       first_conv
);

  localparam logic [1:0] LAST_POS = 2'(NUM_CH - 1);

  logic [1:0] pos_q;
  logic       ls_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      ls_q  <= 1'b0;
    end else begin
      ls_q <= line_start;
      if (!line_start || one_chan) begin
        pos_q <= '0;
      end else if (pos_q == LAST_POS) begin
        pos_q <= '0;
      end else begin
        pos_q <= pos_q + 2'd1;
      end
    end
  end

  always_comb begin
    if (one_chan) begin
      chan_sel = (fixed_sel == CH_RSVD) ? CH_RED : chan_e'(fixed_sel);
    end else begin
      chan_sel = order_map(pos_q, bgr);
    end
  end

  assign first_conv = line_start && !ls_q;

endmodule

// File: rtl/scan_seq_tagpipe.sv
module scan_seq_tagpipe
  import scan_seq_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  tag_t tag_in,
  output tag_t tag_out
);

  tag_t stage_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= tag_in;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign tag_out = stage_q[DEPTH-1];

endmodule

// File: rtl/scan_seq_outreg.sv
module scan_seq_outreg
  import scan_seq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  tag_t              tag_in,
  input  logic [DATA_W-1:0] sample_in,
  output logic              out_valid,
  output logic              out_first,
  output chan_e             out_chan,
  output logic [DATA_W-1:0] out_word
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_chan  <= CH_RED;
      out_word  <= '0;
    end else begin
      out_valid <= tag_in.conv;
      out_first <= tag_in.conv && tag_in.first;
      if (tag_in.conv) begin
        out_chan <= tag_in.chan;
        out_word <= sample_in;
      end
    end
  end

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              cfg_one_chan,
  input  logic [1:0]        cfg_chan_sel,
  input  logic              cfg_bgr,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              out_en_n,
  output logic              conv_start,
  output logic [1:0]        chan_sel,
  output logic              out_valid,
  output logic [1:0]        out_chan,
  output logic              out_first,
  output logic [DATA_W-1:0] out_data
);

  localparam int NUM_CH = 3;
  localparam int PIPE_D = (LATENCY < 1) ? 1 : LATENCY;

  chan_e             sel_e;
  chan_e             out_chan_e;
  logic              first_conv;
  tag_t              tag_launch;
  tag_t              tag_ret;
  logic [DATA_W-1:0] word_q;

  scan_seq_order #(.NUM_CH(NUM_CH)) u_order (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .one_chan   (cfg_one_chan),
    .bgr        (cfg_bgr),
    .fixed_sel  (cfg_chan_sel),
    .chan_sel   (sel_e),
    .first_conv (first_conv)
  );

  assign conv_start       = line_start && !rst;
  assign tag_launch.conv  = conv_start;
  assign tag_launch.first = first_conv;
  assign tag_launch.chan  = sel_e;

  scan_seq_tagpipe #(.DEPTH(PIPE_D)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .tag_in  (tag_launch),
    .tag_out (tag_ret)
  );

  scan_seq_outreg #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .tag_in    (tag_ret),
    .sample_in (sample_in),
    .out_valid (out_valid),
    .out_first (out_first),
    .out_chan  (out_chan_e),
    .out_word  (word_q)
  );

  assign chan_sel = sel_e;
  assign out_chan = out_chan_e;
  assign out_data = out_en_n ? {DATA_W{1'bz}} : word_q;

endmodule

// File: rtl/scan_seq_ctrl_chk.sv
module scan_seq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       line_start,
  input logic       cfg_one_chan,
  input logic [1:0] cfg_chan_sel,
  input logic       cfg_bgr,
  input logic       conv_start,
  input logic [1:0] chan_sel,
  input logic       out_valid,
  input logic       out_first
);

  AST_START_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> line_start); // R1

  AST_IDLE_AT_FIRST: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> (cfg_one_chan || chan_sel == (cfg_bgr ? 2'b10 : 2'b00))); // R2

  AST_SELECT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (line_start && !cfg_one_chan) |=>
      (!line_start || cfg_one_chan || !$stable(cfg_bgr) || chan_sel != $past(chan_sel))); // R3

  AST_GREEN_MIDDLE: assert property (@(posedge clk) disable iff (rst)
    (line_start && !cfg_one_chan && chan_sel == 2'b01) |=>
      (!line_start || cfg_one_chan || !$stable(cfg_bgr) || chan_sel == (cfg_bgr ? 2'b00 : 2'b10))); // R4

  AST_LOCKED_SELECT: assert property (@(posedge clk) disable iff (rst)
    (cfg_one_chan && cfg_chan_sel != 2'b11) |-> chan_sel == cfg_chan_sel); // R5

  AST_RESERVED_RED: assert property (@(posedge clk) disable iff (rst)
    (cfg_one_chan && cfg_chan_sel == 2'b11) |-> chan_sel == 2'b00); // R6

  AST_NEVER_RESERVED: assert property (@(posedge clk) disable iff (rst)
    chan_sel != 2'b11); // R7

  AST_FIRST_IS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_first |-> out_valid); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_first)); // R10

endmodule

bind scan_seq_ctrl scan_seq_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .line_start   (line_start),
  .cfg_one_chan (cfg_one_chan),
  .cfg_chan_sel (cfg_chan_sel),
  .cfg_bgr      (cfg_bgr),
  .conv_start   (conv_start),
  .chan_sel     (chan_sel),
  .out_valid    (out_valid),
  .out_first    (out_first)
);

// File: tb/scan_seq_ctrl_tb.sv
module scan_seq_ctrl_tb;

  localparam int DW  = 12;
  localparam int LAT = 3;
  localparam int RB  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          line_start = 1'b0;
  logic          cfg_one_chan = 1'b0;
  logic [1:0]    cfg_chan_sel = 2'b00;
  logic          cfg_bgr = 1'b0;
  logic [DW-1:0] sample_in = '0;
  logic          out_en_n = 1'b0;
  logic          conv_start;
  logic [1:0]    chan_sel;
  logic          out_valid;
  logic [1:0]    out_chan;
  logic          out_first;
  logic [DW-1:0] out_data;

  always #5 clk = ~clk;

  scan_seq_ctrl #(.DATA_W(DW), .LATENCY(LAT)) u_dut (
    .clk(clk), .rst(rst), .line_start(line_start), .cfg_one_chan(cfg_one_chan),
    .cfg_chan_sel(cfg_chan_sel), .cfg_bgr(cfg_bgr), .sample_in(sample_in),
    .out_en_n(out_en_n), .conv_start(conv_start), .chan_sel(chan_sel),
    .out_valid(out_valid), .out_chan(out_chan), .out_first(out_first),
    .out_data(out_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // Reference model state
  int            pos_m = 0;
  bit            prev_m = 1'b0;
  bit            r_conv [RB];
  bit            r_first[RB];
  logic [1:0]    r_chan [RB];
  logic [DW-1:0] r_smp  [RB];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [1:0] model_sel(input int pos, input bit one,
                                           input logic [1:0] sel, input bit b);
    if (one) return (sel == 2'b11) ? 2'b00 : sel;
    if (pos == 0) return b ? 2'b10 : 2'b00;
    if (pos == 1) return 2'b01;
    return b ? 2'b00 : 2'b10;
  endfunction

  task automatic check_outputs();
    int k;
    k = (cyc - LAT - 1 + 4 * RB) % RB;
    chk(out_valid == r_conv[k], "R1 valid", out_valid, r_conv[k]);
    if (r_conv[k]) begin
      chk(out_chan == r_chan[k], "R8 chan tag", out_chan, r_chan[k]);
      chk(out_first == r_first[k], "R8 first mark", out_first, r_first[k]);
      if (!out_en_n)
        chk(out_data == r_smp[(cyc - 1 + RB) % RB], "R8 word", out_data,
            r_smp[(cyc - 1 + RB) % RB]);
      else
        chk((out_data === {DW{1'bz}}) || (out_data == '0), "R9 float",
            out_data, 0);
    end else begin
      chk(out_first == 1'b0, "R8 first without valid", out_first, 0);
    end
  endtask

  task automatic step(input bit r, input bit ls, input bit one,
                      input logic [1:0] sel, input bit b, input bit oen);
    logic [1:0] es;
    int k;
    @(negedge clk);
    check_outputs();
    rst = r; line_start = ls; cfg_one_chan = one; cfg_chan_sel = sel;
    cfg_bgr = b; out_en_n = oen;
    sample_in = 12'h800 | DW'((cyc * 37) & 12'h7ff);
    #1;
    es = model_sel(pos_m, one, sel, b);
    if (one)
      chk(chan_sel == es, (sel == 2'b11) ? "R6 reserved" : "R5 locked", chan_sel, es);
    else if (!ls)
      chk(chan_sel == es, "R2 idle select", chan_sel, es);
    else if (sel != 2'b00)
      chk(chan_sel == es, "R7 field ignored, R3 R4 order", chan_sel, es);
    else
      chk(chan_sel == es, "R3 R4 order", chan_sel, es);
    chk(conv_start == (ls && !r), "R1 start", conv_start, ls && !r);
    k = cyc % RB;
    r_conv[k]  = ls && !r;
    r_first[k] = ls && !prev_m && !r;
    r_chan[k]  = es;
    r_smp[k]   = sample_in;
    if (r) begin
      pos_m = 0; prev_m = 1'b0;
      for (int i = 0; i < RB; i++) r_conv[i] = 1'b0;
    end else begin
      prev_m = ls;
      pos_m  = (!ls || one) ? 0 : (pos_m + 1) % 3;
    end
    cyc++;
  endtask

  initial begin
    for (int i = 0; i < RB; i++) begin
      r_conv[i] = 1'b0; r_first[i] = 1'b0; r_chan[i] = 2'b00; r_smp[i] = '0;
    end
    repeat (LAT + 2) step(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    // R10: reset state at the ports
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid after reset", out_valid, 0);
    chk(out_first == 1'b0, "R10 first after reset", out_first, 0);
    chk(chan_sel == 2'b00, "R10 select after reset", chan_sel, 0);
    // Sweep every configuration, lines of 7 conversions
    for (int b = 0; b < 2; b++)
      for (int one = 0; one < 2; one++)
        for (int s = 0; s < 4; s++) begin
          repeat (2) step(1'b0, 1'b0, one[0], 2'(s), b[0], (cyc % 5) == 3);
          repeat (7) step(1'b0, 1'b1, one[0], 2'(s), b[0], (cyc % 5) == 3);
          step(1'b0, 1'b0, one[0], 2'(s), b[0], (cyc % 5) == 3);
        end
    // R10: reset with conversions in flight, then a fresh line
    repeat (4) step(1'b0, 1'b1, 1'b0, 2'b10, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0, 2'b10, 1'b1, 1'b0);
    repeat (5) step(1'b0, 1'b1, 1'b0, 2'b10, 1'b1, 1'b0);
    repeat (LAT + 3) step(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1);
    repeat (LAT + 3) step(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule